// File: doc/BRIEF.md
# Trace Search-Back Selection Unit

This block sits between a trace cache read port and the decode latch of a fetch unit. Each cycle it may be handed a candidate trace: up to eight instruction slots, each with its own instruction PC, instruction word and valid bit, plus the trace's stored branch flags and branch mask. It decides whether that trace can supply instructions for the fetch PC the core wants next. When it can, it says which slot fetch begins at, how many valid instructions follow, and it packs those instructions down so that the instruction at the fetch PC lands in output slot 0.

Two matching modes can be selected at run time. In search-back mode every valid slot's PC is compared with the fetch PC in parallel, and the trace may be entered at any internal instruction. This lets one stored loop trace serve several entry points, so fewer copies of the same basic blocks are needed. In first-slot mode the block acts as a conventional trace cache hit test: the fetch PC must equal the first slot's PC and the predicted branch directions must agree with the stored branch flags wherever the mask enables a bit. All results are registered and appear one clock after the request.

Top module: `tsel_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `hit_o`=0, `start_idx_o`=0, `count_o`=0, `out_vld_o`=0 and `out_insn_o`=0.
- R2: In search-back mode (`mode_i`=1) a request hits when any valid slot's PC equals `fetch_pc_i`, and `start_idx_o` is the lowest such slot number (slot i occupies bits [i*PC_W +: PC_W] of `slot_pc_i`).
- R3: On a hit, output slot k carries the instruction and valid bit of input slot `start_idx_o`+k; input slots below the start index are not delivered; output slots with `start_idx_o`+k beyond the last slot are invalid; every invalid output slot carries an all-zero instruction word.
- R4: On a hit, `count_o` equals the number of valid input slots from `start_idx_o` through the last slot, holes included in the shift but not in the count.
- R5: A slot whose valid bit is 0 never matches, and a trace with no valid slot never hits.
- R6: In first-slot mode (`mode_i`=0) a hit needs slot 0 valid and its PC equal to `fetch_pc_i`; matches in other slots are ignored, and `start_idx_o` is 0.
- R7: In first-slot mode a hit also needs `((br_pred_i ^ br_flags_i) & br_mask_i) == 0`; prediction bits whose mask bit is 0 have no effect.
- R8: In search-back mode the branch prediction, flag and mask inputs have no effect on the result.
- R9: On a miss, `hit_o`=0 and `start_idx_o`, `count_o`, `out_vld_o` and `out_insn_o` are all zero.
- R10: Outputs reflect the inputs present at the previous rising edge; with `req_i` low at that edge the outputs are the miss values of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Selection request for this cycle |
| mode_i | input | 1 | 1 = search-back, 0 = first-slot only |
| fetch_pc_i | input | PC_W | PC to be fetched next |
| slot_pc_i | input | SLOTS*PC_W | Per-slot instruction PCs, slot 0 lowest |
| slot_insn_i | input | SLOTS*INSN_W | Per-slot instruction words, slot 0 lowest |
| slot_vld_i | input | SLOTS | Per-slot valid bits |
| br_pred_i | input | BR_W | Predicted branch directions |
| br_flags_i | input | BR_W | Branch directions stored with the trace |
| br_mask_i | input | BR_W | Enables for the branch comparison |
| hit_o | output | 1 | Trace supplies the fetch PC |
| start_idx_o | output | clog2(SLOTS) | Slot where fetch begins |
| count_o | output | clog2(SLOTS+1) | Valid instructions delivered |
| out_insn_o | output | SLOTS*INSN_W | Realigned instruction words |
| out_vld_o | output | SLOTS | Realigned valid bits |

## Verification
The hardest case to reach from the ports is a trace in which the fetch PC appears more than once, or appears only in an invalid slot, while holes sit among the valid slots after the match; only then do earliest-match priority, the valid gating and the hole-aware count separate from one another. The stimulus builds such traces on purpose (duplicated PCs, a matching PC placed only under a cleared valid bit, a hole after the start slot) and then runs a long random phase drawing slot PCs from a tiny value range, so repeated and masked matches occur often in both modes against the bench's own model.

// File: rtl/tsel_pkg.sv
// Package: shared mode encoding for the trace selection unit.
// Assumes: mode input is one bit wide.
package tsel_pkg;
    typedef enum logic {
        SEL_FIRST  = 1'b0,   // conventional: first slot plus branch check
        SEL_SEARCH = 1'b1    // match any valid slot
    } sel_mode_e;
endpackage

// File: rtl/tsel_cmp_bank.sv
// Module: tsel_cmp_bank
// One equality comparator per slot, all in parallel. A slot reports a match
// only when its valid bit is set. Assumes slot PCs are packed slot 0 lowest.
module tsel_cmp_bank #(
    parameter int SLOTS = 8,
    parameter int PC_W  = 32
) (
    input  logic [PC_W-1:0]       fetch_pc,
    input  logic [SLOTS*PC_W-1:0] slot_pc,
    input  logic [SLOTS-1:0]      slot_vld,
    output logic [SLOTS-1:0]      match_vec
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        // compare this slot's PC with the fetch PC, gated by its valid bit
        assign match_vec[g] = slot_vld[g] && (slot_pc[g*PC_W +: PC_W] == fetch_pc);
    end
endmodule

// File: rtl/tsel_first_find.sv
// Module: tsel_first_find
// Finds the lowest set bit of the match vector. Assumes nothing about how
// many bits are set; index is 0 when none is.
module tsel_first_find #(
    parameter int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [SLOTS-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // scan from the top down so the lowest match is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tsel_align.sv
// Module: tsel_align
// Shifts the trace down by the start index so the start slot lands in
// output slot 0, and counts valid slots from the start index to the end.
// Assumes idx < SLOTS. Invalid output slots carry zero instruction words.
module tsel_align #(
    parameter int SLOTS  = 8,
    parameter int INSN_W = 32,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [SLOTS*INSN_W-1:0] insn_in,
    input  logic [SLOTS-1:0]        vld_in,
    output logic [SLOTS*INSN_W-1:0] insn_out,
    output logic [SLOTS-1:0]        vld_out,
    output logic [CNT_W-1:0]        count
);
    // realign slots: output k takes input idx+k when it exists
    always_comb begin
        insn_out = '0;
        vld_out  = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (int'(idx) + k < SLOTS) begin
                vld_out[k] = vld_in[int'(idx) + k];
                if (vld_in[int'(idx) + k]) begin
                    insn_out[k*INSN_W +: INSN_W] = insn_in[(int'(idx) + k)*INSN_W +: INSN_W];
                end
            end
        end
    end

    // count valid slots at or after the start index
    always_comb begin
        count = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i >= int'(idx) && vld_in[i]) begin
                count = count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tsel_top.sv
// Module: tsel_top
// Trace selection with search-back. Picks whether a candidate trace serves
// the fetch PC (any valid slot in search-back mode, slot 0 plus masked branch
// agreement in first-slot mode), realigns it and registers the result.
// Assumes: one request per cycle, results one clock later, synchronous
// active-low reset.
module tsel_top
    import tsel_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int PC_W   = 32,
    parameter int INSN_W = 32,
    parameter int BR_W   = 3,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic                    mode_i,
    input  logic [PC_W-1:0]         fetch_pc_i,
    input  logic [SLOTS*PC_W-1:0]   slot_pc_i,
    input  logic [SLOTS*INSN_W-1:0] slot_insn_i,
    input  logic [SLOTS-1:0]        slot_vld_i,
    input  logic [BR_W-1:0]         br_pred_i,
    input  logic [BR_W-1:0]         br_flags_i,
    input  logic [BR_W-1:0]         br_mask_i,
    output logic                    hit_o,
    output logic [IDX_W-1:0]        start_idx_o,
    output logic [CNT_W-1:0]        count_o,
    output logic [SLOTS*INSN_W-1:0] out_insn_o,
    output logic [SLOTS-1:0]        out_vld_o
);
    sel_mode_e               mode;
    logic [SLOTS-1:0]        match_vec;
    logic                    any_match;
    logic [IDX_W-1:0]        first_idx;
    logic                    br_agree;
    logic                    sel_hit;
    logic [IDX_W-1:0]        sel_idx;
    logic [SLOTS*INSN_W-1:0] al_insn;
    logic [SLOTS-1:0]        al_vld;
    logic [CNT_W-1:0]        al_count;

    assign mode = sel_mode_e'(mode_i);

    tsel_cmp_bank #(.SLOTS(SLOTS), .PC_W(PC_W)) u_cmp (
        .fetch_pc  (fetch_pc_i),
        .slot_pc   (slot_pc_i),
        .slot_vld  (slot_vld_i),
        .match_vec (match_vec)
    );

    tsel_first_find #(.SLOTS(SLOTS)) u_find (
        .vec   (match_vec),
        .found (any_match),
        .idx   (first_idx)
    );

    // branch directions agree wherever the trace's mask enables a bit
    always_comb begin
        br_agree = (((br_pred_i ^ br_flags_i) & br_mask_i) == '0);
    end

    // choose hit and start slot according to the matching mode
    always_comb begin
        if (mode == SEL_SEARCH) begin
            sel_hit = req_i && any_match;
            sel_idx = first_idx;
        end else begin
            sel_hit = req_i && match_vec[0] && br_agree;
            sel_idx = '0;
        end
    end

    tsel_align #(.SLOTS(SLOTS), .INSN_W(INSN_W)) u_align (
        .idx      (sel_idx),
        .insn_in  (slot_insn_i),
        .vld_in   (slot_vld_i),
        .insn_out (al_insn),
        .vld_out  (al_vld),
        .count    (al_count)
    );

    // register the selection result; a miss or idle cycle clears everything
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_hit) begin
            hit_o       <= 1'b0;
            start_idx_o <= '0;
            count_o     <= '0;
            out_insn_o  <= '0;
            out_vld_o   <= '0;
        end else begin
            hit_o       <= 1'b1;
            start_idx_o <= sel_idx;
            count_o     <= al_count;
            out_insn_o  <= al_insn;
            out_vld_o   <= al_vld;
        end
    end

    // R9: a registered miss leaves no valid slot and no count
    p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (out_vld_o == '0 && count_o == '0 && start_idx_o == '0));

    // R4: count agrees with the delivered valid bits
    p_count_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (count_o == CNT_W'($countones(out_vld_o))));

    // R3: the start instruction always sits valid in output slot 0
    p_head_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> out_vld_o[0]);

    // R10: no request means no hit one clock later
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !hit_o);

    // R6: first-slot mode always starts at slot 0
    p_first_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !mode_i) |=> (start_idx_o == '0));

    // R7: a masked branch disagreement blocks a first-slot hit
    p_branch_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !mode_i && ((br_pred_i ^ br_flags_i) & br_mask_i) != '0) |=> !hit_o);

    // R5: a trace without valid slots never hits
    p_empty_trace_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld_i == '0) |=> !hit_o);
endmodule

// File: tb/tsel_top_tb.sv
module tsel_top_tb;
    localparam int S  = 8;
    localparam int PW = 32;
    localparam int IW = 32;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic          mode;
    logic [PW-1:0] fpc;
    logic [S*PW-1:0] spc;
    logic [S*IW-1:0] sins;
    logic [S-1:0]    svld;
    logic [BW-1:0]   pred, flags, mask;
    logic            hit;
    logic [2:0]      sidx;
    logic [3:0]      cnt;
    logic [S*IW-1:0] oins;
    logic [S-1:0]    ovld;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // expected values from the model
    logic            e_hit;
    int              e_idx, e_cnt;
    logic [S*IW-1:0] e_ins;
    logic [S-1:0]    e_vld;

    always #5 clk = ~clk;

    tsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .fetch_pc_i(fpc), .slot_pc_i(spc), .slot_insn_i(sins), .slot_vld_i(svld),
        .br_pred_i(pred), .br_flags_i(flags), .br_mask_i(mask),
        .hit_o(hit), .start_idx_o(sidx), .count_o(cnt),
        .out_insn_o(oins), .out_vld_o(ovld)
    );

    // behavioural model of the requirements
    task automatic model();
        int start = -1;
        e_hit = 0; e_idx = 0; e_cnt = 0; e_ins = '0; e_vld = '0;
        if (!rst_n || !req) return;
        if (mode) begin
            for (int i = 0; i < S; i++)
                if (start < 0 && svld[i] && spc[i*PW +: PW] == fpc) start = i;
        end else begin
            if (svld[0] && spc[PW-1:0] == fpc && ((pred ^ flags) & mask) == 0) start = 0;
        end
        if (start < 0) return;
        e_hit = 1; e_idx = start;
        for (int i = start; i < S; i++) begin
            if (svld[i]) begin
                e_cnt++;
                e_vld[i-start] = 1'b1;
                e_ins[(i-start)*IW +: IW] = sins[i*IW +: IW];
            end
        end
    endtask

    task automatic check(string req_tag);
        tests++;
        if (hit !== e_hit || int'(sidx) != e_idx || int'(cnt) != e_cnt ||
            ovld !== e_vld || oins !== e_ins) begin
            fails++;
            $display("FAIL %s: got hit=%0b idx=%0d cnt=%0d vld=%b ins=%h exp hit=%0b idx=%0d cnt=%0d vld=%b ins=%h",
                     req_tag, hit, sidx, cnt, ovld, oins, e_hit, e_idx, e_cnt, e_vld, e_ins);
        end
    endtask

    // apply at negedge, evaluate model, sample at next negedge
    task automatic step(string req_tag);
        model();
        @(posedge clk);
        @(negedge clk);
        check(req_tag);
    endtask

    // fill a trace: PCs base+4*i, words tagged by slot, all valid
    task automatic fill(logic [PW-1:0] base);
        for (int i = 0; i < S; i++) begin
            spc[i*PW +: PW]  = base + PW'(4*i);
            sins[i*IW +: IW] = 32'hA000_0000 + IW'(i * 17 + base);
        end
        svld = '1;
    endtask

    initial begin
        rst_n = 0; req = 1; mode = 1; fpc = 32'h100;
        pred = 0; flags = 0; mask = 0;
        fill(32'h100);
        @(negedge clk);
        step("R1");                       // reset with a matching request
        rst_n = 1;

        // R2: fetch PC duplicated in slots 3 and 6, earliest wins
        fill(32'h200);
        spc[6*PW +: PW] = 32'h20C; fpc = 32'h20C;
        step("R2");

        // R3: match at slot 5, tail shifted to slot 0
        fill(32'h300); fpc = 32'h314;
        step("R3");

        // R4: hole at slot 6 after match at slot 2
        fill(32'h400); svld[6] = 0; svld[0] = 0; fpc = 32'h408;
        step("R4");

        // R5: only matching slot is invalid
        fill(32'h500); svld[4] = 0; fpc = 32'h510;
        step("R5");
        // R5: fully invalid trace
        fill(32'h500); svld = '0; fpc = 32'h500;
        step("R5");

        // R6: first-slot mode ignores internal match
        mode = 0; fill(32'h600); fpc = 32'h610;
        step("R6");
        // R6: first-slot hit delivers the whole trace
        fpc = 32'h600;
        step("R6");

        // R7: disagreement on an enabled bit blocks the hit
        pred = 3'b010; flags = 3'b000; mask = 3'b010;
        step("R7");
        // R7: disagreement only on disabled bits has no effect
        mask = 3'b101;
        step("R7");

        // R8: search-back ignores a full branch disagreement
        mode = 1; pred = 3'b111; flags = 3'b000; mask = 3'b111; fpc = 32'h618;
        step("R8");

        // R9: plain miss with unrelated PC
        fpc = 32'hDEAD_0000;
        step("R9");

        // R10: matching trace but no request
        req = 0; fpc = 32'h600;
        step("R10");
        req = 1;
        step("R10");

        // random phase: tiny PC range gives repeated and masked matches
        for (int n = 0; n < 400; n++) begin
            mode = 1'($urandom_range(0, 1));
            req  = ($urandom_range(0, 7) != 0);
            for (int i = 0; i < S; i++) begin
                spc[i*PW +: PW]  = PW'($urandom_range(0, 5));
                sins[i*IW +: IW] = $urandom;
            end
            svld  = S'($urandom);
            fpc   = PW'($urandom_range(0, 5));
            pred  = BW'($urandom); flags = BW'($urandom); mask = BW'($urandom);
            step(mode ? "R2" : "R6");
        end

        // R1 again: reset mid-run clears outputs
        rst_n = 0; fill(32'h700); fpc = 32'h700; mode = 1; req = 1;
        step("R1");
        rst_n = 1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule